// File: doc/BRIEF.md
# External Interrupt Controller

This block watches a vector of external interrupt lines. It turns each line into latched events and combines the pending, unmasked events into one interrupt request for the processor. Each line is first passed through a two-flop synchronizer. It is then classified by its own configuration: edge sensing (rising or falling) or level sensing (active-high or active-low). A qualifying event sets that line's bit in a status register. The bit stays set until software clears it by writing a one to that bit.

A mask holds one bit per line. It is never written directly. Writing ones to a set port turns mask bits on, and writing ones to a separate reset port turns them off. The interrupt output is high whenever any line is both pending and unmasked. A single control bit drives the enable of the non-maskable interrupt path.

Lines above the implemented count have no storage and read back as zero. Software can therefore write all ones to the sense-mode register and count the bits that read back as one, which gives the number of lines.

Top module: `eirq_ctrl`

## Requirements
- R1: After reset, the mask, status, sense-mode, edge-select, level-select and NMI-control registers read 0, and `irq_out` and `nmi_en` are 0.
- R2: A write to 0x00 turns on every mask bit whose written bit is 1. A write to 0x04 turns off every mask bit whose written bit is 1. Written zeros leave the mask unchanged in both cases. The mask reads at 0x08.
- R3: The status register reads at 0x0C. A write to 0x10 clears every status bit whose written bit is 1. If a new event arrives for a line in the same cycle as its clear, the bit stays set.
- R4: The sense-mode register is at 0x14: bit value 0 selects edge sensing for that line. The edge-select register is at 0x18: 1 selects rising edges and 0 selects falling edges. An input change becomes visible in status after the third rising clock edge.
- R5: Bit value 1 in the sense-mode register selects level sensing. The level-select register is at 0x1C: 1 selects active-high and 0 selects active-low. While a level-sensed line is active, its status bit is set again on every cycle, so a clear only sticks once the line is inactive.
- R6: Bits at or above NLINES in the sense-mode, edge-select, level-select, mask and status registers cannot be written and read as 0. Writing all ones to 0x14 and reading it back gives 2^NLINES-1.
- R7: `irq_out` is 1 exactly when some line has both its status bit and its mask bit set. It follows these registers in the same cycle.
- R8: Bit 0 of the register at 0x24 is the NMI enable and drives `nmi_en`. The other bits of 0x24 read 0.
- R9: Reads of the write-only offsets 0x00, 0x04 and 0x10, and of any unmapped offset, return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the accessed register |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_lines | input | NLINES | External interrupt inputs, asynchronous |
| irq_out | output | 1 | Combined interrupt request |
| nmi_en | output | 1 | NMI path enable |

## Verification
The lines are driven with isolated pulses and with a walking pattern. This is done in rising, falling, active-high and active-low configurations, so a swapped polarity or a swapped mode bit shows up as a missing or extra status bit. The test holds a level line active across repeated clears, and it times a clear to land on the same cycle as a new edge. Together these separate set-over-clear priority from clear-over-set priority. The mask is changed with overlapping and zero-valued set and reset writes, and the status bits are left pending while masked. This shows that the request output depends on both registers and that zeros in a write do nothing.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam logic [AW-1:0] OFS_SET    = 8'h00;
    localparam logic [AW-1:0] OFS_RESET  = 8'h04;
    localparam logic [AW-1:0] OFS_MASK   = 8'h08;
    localparam logic [AW-1:0] OFS_STATUS = 8'h0C;
    localparam logic [AW-1:0] OFS_CLEAR  = 8'h10;
    localparam logic [AW-1:0] OFS_MODE   = 8'h14;
    localparam logic [AW-1:0] OFS_EDGE   = 8'h18;
    localparam logic [AW-1:0] OFS_LEVEL  = 8'h1C;
    localparam logic [AW-1:0] OFS_NMI    = 8'h24;
endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    typedef struct packed {
        logic [W-1:0] stage1;
        logic [W-1:0] stage2;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.stage1 = async_in;
        s_d.stage2 = s_q.stage1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sync_out = s_q.stage2;
endmodule

// File: rtl/eirq_detect.sv
module eirq_detect #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] line_s,
    input  logic [W-1:0] mode_lvl,
    input  logic [W-1:0] edge_rise,
    input  logic [W-1:0] lvl_high,
    output logic [W-1:0] evt
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = line_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar i = 0; i < W; i++) begin : g_line
        logic rise, fall, active;
        assign rise   = line_s[i] & ~prev_q[i];
        assign fall   = ~line_s[i] & prev_q[i];
        assign active = lvl_high[i] ? line_s[i] : ~line_s[i];
        assign evt[i] = mode_lvl[i] ? active : (edge_rise[i] ? rise : fall);
    end

    // R4: an edge-sensed event implies the synchronized line moved this cycle
    assert_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt & ~mode_lvl & (line_s ^ prev_q)) == (evt & ~mode_lvl)));
endmodule

// File: rtl/eirq_regfile.sv
module eirq_regfile #(
    parameter int W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [eirq_pkg::AW-1:0]  addr,
    input  logic                     we,
    input  logic [eirq_pkg::DW-1:0]  wdata,
    input  logic [W-1:0]             evt,
    output logic [W-1:0]             mask_o,
    output logic [W-1:0]             status_o,
    output logic [W-1:0]             mode_o,
    output logic [W-1:0]             edge_o,
    output logic [W-1:0]             level_o,
    output logic                     nmi_o,
    output logic [eirq_pkg::DW-1:0]  rdata
);
    import eirq_pkg::*;

    typedef struct packed {
        logic [W-1:0] mask;
        logic [W-1:0] status;
        logic [W-1:0] mode;
        logic [W-1:0] edge_sel;
        logic [W-1:0] level;
        logic         nmi;
    } regs_t;

    regs_t r_d, r_q;
    logic [W-1:0] wbits;
    logic [W-1:0] clr;

    assign wbits = wdata[W-1:0];

    function automatic logic [DW-1:0] widen(input logic [W-1:0] v);
        logic [DW-1:0] r;
        r = '0;
        r[W-1:0] = v;
        return r;
    endfunction

    always_comb begin
        r_d = r_q;
        clr = '0;
        if (we) begin
            case (addr)
                OFS_SET:   r_d.mask     = r_q.mask | wbits;
                OFS_RESET: r_d.mask     = r_q.mask & ~wbits;
                OFS_CLEAR: clr          = wbits;
                OFS_MODE:  r_d.mode     = wbits;
                OFS_EDGE:  r_d.edge_sel = wbits;
                OFS_LEVEL: r_d.level    = wbits;
                OFS_NMI:   r_d.nmi      = wdata[0];
                default:   ;
            endcase
        end
        r_d.status = (r_q.status & ~clr) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (addr)
            OFS_MASK:   rdata = widen(r_q.mask);
            OFS_STATUS: rdata = widen(r_q.status);
            OFS_MODE:   rdata = widen(r_q.mode);
            OFS_EDGE:   rdata = widen(r_q.edge_sel);
            OFS_LEVEL:  rdata = widen(r_q.level);
            OFS_NMI:    rdata = {{(DW-1){1'b0}}, r_q.nmi};
            default:    rdata = '0;
        endcase
    end

    assign mask_o   = r_q.mask;
    assign status_o = r_q.status;
    assign mode_o   = r_q.mode;
    assign edge_o   = r_q.edge_sel;
    assign level_o  = r_q.level;
    assign nmi_o    = r_q.nmi;

    // R2: ones written to the set port appear in the mask
    assert_mask_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(we) && $past(addr) == OFS_SET) |-> ((mask_o & $past(wbits)) == $past(wbits)));
    // R2: ones written to the reset port are gone from the mask
    assert_mask_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(we) && $past(addr) == OFS_RESET) |-> ((mask_o & $past(wbits)) == '0));
    // R3: a cleared bit without a coincident event reads 0 afterwards
    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(we) && $past(addr) == OFS_CLEAR) |-> ((status_o & $past(wbits) & ~$past(evt)) == '0));
    // R8: the NMI enable follows bit 0 of a control write
    assert_nmi_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(we) && $past(addr) == OFS_NMI) |-> (nmi_o == $past(wdata[0])));
endmodule

// File: rtl/eirq_ctrl.sv
module eirq_ctrl #(
    parameter int NLINES = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [eirq_pkg::AW-1:0]  bus_addr,
    input  logic                     bus_we,
    input  logic [eirq_pkg::DW-1:0]  bus_wdata,
    output logic [eirq_pkg::DW-1:0]  bus_rdata,
    input  logic [NLINES-1:0]        irq_lines,
    output logic                     irq_out,
    output logic                     nmi_en
);
    logic [NLINES-1:0] line_s, evt;
    logic [NLINES-1:0] mask_q, status_q, mode_q, edge_q, level_q;

    eirq_sync #(.W(NLINES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(irq_lines), .sync_out(line_s)
    );

    eirq_detect #(.W(NLINES)) u_detect (
        .clk(clk), .rst_n(rst_n), .line_s(line_s), .mode_lvl(mode_q),
        .edge_rise(edge_q), .lvl_high(level_q), .evt(evt)
    );

    eirq_regfile #(.W(NLINES)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
        .evt(evt), .mask_o(mask_q), .status_o(status_q), .mode_o(mode_q),
        .edge_o(edge_q), .level_o(level_q), .nmi_o(nmi_en), .rdata(bus_rdata)
    );

    assign irq_out = |(status_q & mask_q);

    // R5: every detected event is latched in status on the next edge
    assert_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & $past(evt)) == $past(evt)));
    // R7: with the mask empty no request leaves the block
    assert_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq_out);
endmodule

// File: tb/eirq_ctrl_test.sv
module eirq_ctrl_test;
    localparam int NL = 8;
    localparam logic [31:0] IMP = (NL >= 32) ? 32'hFFFF_FFFF : ((32'h1 << NL) - 32'h1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] b_addr = 8'h0C;
    logic b_we = 1'b0;
    logic [31:0] b_wdata = '0;
    logic [NL-1:0] lines = '0;
    logic [31:0] rdata;
    logic irq_out, nmi_en;

    int vectors = 0;
    int fails = 0;
    bit done = 0;
    string tag = "R1";

    eirq_ctrl #(.NLINES(NL)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(b_addr), .bus_we(b_we),
        .bus_wdata(b_wdata), .bus_rdata(rdata), .irq_lines(lines),
        .irq_out(irq_out), .nmi_en(nmi_en)
    );

    always #5 clk = ~clk;

    // behavioural reference model
    logic [31:0] m_s1, m_s2, m_prev, m_stat, m_mask, m_mode, m_edge, m_lvl;
    logic m_nmi;
    logic [31:0] ev, clrv;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_prev = 0; m_stat = 0; m_mask = 0;
            m_mode = 0; m_edge = 0; m_lvl = 0; m_nmi = 0;
        end else begin
            ev = 0;
            for (int i = 0; i < NL; i++) begin
                if (m_mode[i])      ev[i] = m_lvl[i] ? m_s2[i] : !m_s2[i];
                else if (m_edge[i]) ev[i] = m_s2[i] && !m_prev[i];
                else                ev[i] = !m_s2[i] && m_prev[i];
            end
            clrv = 0;
            if (b_we) begin
                if (b_addr == 8'h00) m_mask = m_mask | (b_wdata & IMP);
                if (b_addr == 8'h04) m_mask = m_mask & ~b_wdata;
                if (b_addr == 8'h10) clrv = b_wdata;
                if (b_addr == 8'h14) m_mode = b_wdata & IMP;
                if (b_addr == 8'h18) m_edge = b_wdata & IMP;
                if (b_addr == 8'h1C) m_lvl = b_wdata & IMP;
                if (b_addr == 8'h24) m_nmi = b_wdata[0];
            end
            m_stat = ((m_stat & ~clrv) | ev) & IMP;
            m_prev = m_s2;
            m_s2 = m_s1;
            m_s1 = 32'(lines);
        end
    end

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        case (a)
            8'h08: return m_mask;
            8'h0C: return m_stat;
            8'h14: return m_mode;
            8'h18: return m_edge;
            8'h1C: return m_lvl;
            8'h24: return {31'b0, m_nmi};
            default: return 32'h0;
        endcase
    endfunction

    task automatic compare();
        logic [31:0] er;
        logic ei;
        er = exp_rd(b_addr);
        ei = |(m_stat & m_mask);
        vectors++;
        if (rdata !== er || irq_out !== ei || nmi_en !== m_nmi) begin
            fails++;
            $display("FAIL %s addr=%02h rdata=%08h/%08h irq=%b/%b nmi=%b/%b (actual/expected)",
                     tag, b_addr, rdata, er, irq_out, ei, nmi_en, m_nmi);
        end
    endtask

    task automatic cyc(input logic [7:0] a, input logic w, input logic [31:0] d);
        @(negedge clk);
        compare();
        b_addr = a; b_we = w; b_wdata = d;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        cyc(a, 1'b1, d);
    endtask

    task automatic rd(input logic [7:0] a);
        cyc(a, 1'b0, 32'h0);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) rd(8'h0C);
    endtask

    task automatic drive(input logic [NL-1:0] v);
        @(negedge clk);
        compare();
        lines = v; b_addr = 8'h0C; b_we = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        tag = "R1";
        repeat (3) begin @(negedge clk); compare(); end
        rst_n = 1'b1;
        foreach (exp_rd_list[i]) rd(exp_rd_list[i]);
        idle(1);

        tag = "R6";
        wr(8'h14, 32'hFFFF_FFFF); rd(8'h14); rd(8'h14);
        wr(8'h14, 32'h0);
        wr(8'h18, 32'hFFFF_FFFF); rd(8'h18); wr(8'h18, 32'h0);
        wr(8'h1C, 32'hFFFF_FFFF); rd(8'h1C); wr(8'h1C, 32'h0);

        tag = "R2";
        wr(8'h00, 32'hFFFF_FFFF); rd(8'h08);
        wr(8'h04, 32'h0000_000F); rd(8'h08);
        wr(8'h00, 32'h0); rd(8'h08);
        wr(8'h04, 32'h0); rd(8'h08);
        wr(8'h00, 32'h0000_0003); rd(8'h08);

        tag = "R4";
        wr(8'h18, 32'h0000_0001);
        drive(8'h01); idle(5);
        tag = "R3";
        wr(8'h10, 32'h0000_0001); idle(2);
        tag = "R4";
        drive(8'h00); idle(5);
        drive(8'h02); idle(4); drive(8'h00); idle(5);

        tag = "R7";
        wr(8'h04, 32'hFF); idle(2);
        wr(8'h00, 32'h02); idle(2);
        wr(8'h00, 32'h01); idle(1);
        tag = "R3";
        wr(8'h10, 32'hFF); idle(2);

        tag = "R5";
        wr(8'h00, 32'hFF);
        wr(8'h1C, 32'h04); wr(8'h14, 32'h04);
        drive(8'h04); idle(4);
        wr(8'h10, 32'h04); idle(2); wr(8'h10, 32'h04); idle(1);
        drive(8'h00); idle(4);
        wr(8'h10, 32'h04); idle(3);
        wr(8'h14, 32'h0C); idle(4);
        drive(8'h08); idle(4);
        wr(8'h10, 32'h08); idle(3);
        wr(8'h14, 32'h00); wr(8'h10, 32'hFF); idle(2);

        tag = "R3";
        wr(8'h18, 32'h10);
        drive(8'h18);
        for (int k = 0; k < 5; k++) wr(8'h10, 32'h10);
        idle(2);
        wr(8'h10, 32'hFF); idle(1);

        tag = "R4";
        wr(8'h18, 32'h55);
        for (int k = 0; k < NL; k++) begin drive(NL'(1) << k); idle(3); end
        drive('0); idle(4);
        for (int k = 0; k < NL; k++) begin drive(~(NL'(1) << k)); idle(3); end
        drive('0); idle(4);
        wr(8'h10, 32'hFF); idle(2);

        tag = "R8";
        wr(8'h24, 32'hFFFF_FFFF); rd(8'h24); rd(8'h24);
        wr(8'h24, 32'h0000_0002); rd(8'h24);
        wr(8'h24, 32'h1); wr(8'h24, 32'h0); rd(8'h24);

        tag = "R9";
        wr(8'h00, 32'h0F);
        rd(8'h00); rd(8'h04); rd(8'h10); rd(8'h20); rd(8'h28); rd(8'hFC);
        idle(2);

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    logic [7:0] exp_rd_list [10] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10,
                                     8'h14, 8'h18, 8'h1C, 8'h20, 8'h24};
endmodule